// File: doc/BRIEF.md
# TPM Command Send Sequencer

This block pushes a single TPM command into the device through a byte-wide register engine that performs the serial framing. One `start` pulse with a byte count begins a fixed sequence. The sequencer first makes sure locality 0 is held, then brings the device into the command-ready state. It moves every byte except the last into the data FIFO, in pieces no larger than the burst count the device reports. It checks the data-expect flag before and after the final byte, and then issues the execute request. Command bytes come from a show-ahead byte source: `cmd_byte` always shows the next byte, and `cmd_take` consumes it.

Each register access is a request held on `eng_req` until the engine returns `eng_ack`. When the access is a read, `eng_rdata` carries the value in the ack cycle. When it is a write, `eng_fail` reports a bad status from the device. A data FIFO write carries a byte count on `eng_len`, and the engine strobes `eng_beat` once for each byte it takes. Polling loops are spaced by an idle gap and bounded by three cycle-count timeouts. Any failure after bus activity has begun ends with a cleanup pair of writes. A single `done` pulse reports the outcome.

Top module: `tpm_cmd_sender`

## Requirements
- R1: A start with `cmd_len` below MIN_LEN (10) produces `done` on the next cycle with `err_code`=1 and no register access; a length of exactly 10 is accepted. Result codes: 0 success, 1 too short, 2 timeout, 3 I/O error.
- R2: The first access is a read of the access register (address 0x00). If that read shows bit 7 (valid) and bit 5 (active locality) both set, no locality request is written.
- R3: Otherwise the sequencer writes 0x02 (request use) to 0x00 and re-reads 0x00 until bits 7 and 5 are both set. If a read still fails once TMO_A cycles have passed since the request, the run ends with code 2.
- R4: The status register (0x18) is then read. If bit 6 (command ready) is clear, the sequencer writes 0x40 to 0x18 and re-reads 0x18 until bit 6 is set. The timeout for this loop is TMO_B cycles, and it ends the run with code 2.
- R5: The burst count is read from 0x19 (low byte) and then from 0x1A (high byte). A zero count restarts the pair. If TMO_D cycles pass without a non-zero count, the run ends with code 2.
- R6: Each piece is written to 0x24 with `eng_len` equal to the smaller of the burst count and the bytes still to send, excluding the last byte. The bytes are taken from the source in order, one per `eng_beat`, and `cmd_take` asserts only on those beats.
- R7: After all bytes but the last, 0x18 is read; bit 3 (data expect) clear there ends the run with code 3.
- R8: The final byte is written to 0x24 as a one-byte access; 0x18 is then read and bit 3 still set ends the run with code 3.
- R9: On success 0x20 (execute) is written to 0x18, followed by `done` with code 0.
- R10: Every timeout or I/O error after the first access writes 0x40 to 0x18 and then 0x20 to 0x00, in that order, before `done`.
- R11: `eng_fail` on the ack of any write before cleanup ends the run with code 3 and the R10 cleanup.
- R12: `busy` is high from an accepted start until after `done`; `done` is a one-cycle pulse; while idle no request is raised, and a start in the `done` cycle is ignored.
- R13: A request keeps its address and direction until its ack, and repeated poll reads are separated by at least POLL_GAP cycles with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin one command transfer |
| cmd_len | input | LEN_W | Total command length in bytes, sampled with start |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | Result: 0 ok, 1 short, 2 timeout, 3 I/O |
| cmd_byte | input | 8 | Next command byte from the source (show-ahead) |
| cmd_take | output | 1 | Consume the current command byte |
| eng_req | output | 1 | Register access request, held until ack |
| eng_wr | output | 1 | Access is a write |
| eng_addr | output | 8 | Register address |
| eng_wdata | output | 8 | Write byte (the command byte during FIFO writes) |
| eng_len | output | LEN_W | Byte count of the access |
| eng_ack | input | 1 | Access complete |
| eng_fail | input | 1 | Device reported a bad status for a write |
| eng_rdata | input | 8 | Read byte, valid with ack |
| eng_beat | input | 1 | Engine takes one FIFO byte this cycle |

## Verification
Two events can meet in the same cycle. A poll read can come back good exactly when its timeout window has already run out; the design then counts the good read as success. A new start can also arrive in the very cycle of the `done` pulse. The bench provokes the first case with device models that grant only after several polls, or never, and it compares every register access against a sequence it builds from the requirements. It provokes the second by pulsing `start` in the sampled `done` cycle and then checking that the bus stays silent and `busy` stays low.

// File: rtl/tpm_cmd_sender.sv
module tpm_cmd_sender #(
  parameter int LEN_W    = 16,
  parameter int MIN_LEN  = 10,
  parameter int TMO_A    = 2000,
  parameter int TMO_B    = 20000,
  parameter int TMO_D    = 2000,
  parameter int POLL_GAP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err_code,
  input  logic [7:0]       cmd_byte,
  output logic             cmd_take,
  output logic             eng_req,
  output logic             eng_wr,
  output logic [7:0]       eng_addr,
  output logic [7:0]       eng_wdata,
  output logic [LEN_W-1:0] eng_len,
  input  logic             eng_ack,
  input  logic             eng_fail,
  input  logic [7:0]       eng_rdata,
  input  logic             eng_beat
);

  localparam int TMO_AB  = (TMO_A > TMO_B) ? TMO_A : TMO_B;
  localparam int TMO_MAX = (TMO_AB > TMO_D) ? TMO_AB : TMO_D;
  localparam int CNT_W   = $clog2(TMO_MAX + 2);
  localparam int GAP_W   = $clog2(POLL_GAP + 1);

  localparam logic [7:0] RG_ACCESS = 8'h00;
  localparam logic [7:0] RG_STS    = 8'h18;
  localparam logic [7:0] RG_BC_LO  = 8'h19;
  localparam logic [7:0] RG_BC_HI  = 8'h1A;
  localparam logic [7:0] RG_FIFO   = 8'h24;

  localparam logic [7:0] ACC_OWNED = 8'hA0;
  localparam logic [7:0] ACC_ASK   = 8'h02;
  localparam logic [7:0] ACC_DROP  = 8'h20;
  localparam logic [7:0] STS_RDY   = 8'h40;
  localparam logic [7:0] STS_EXEC  = 8'h20;
  localparam int         BIT_RDY   = 6;
  localparam int         BIT_EXP   = 3;

  localparam logic [1:0] RES_OK    = 2'd0;
  localparam logic [1:0] RES_SHORT = 2'd1;
  localparam logic [1:0] RES_TIME  = 2'd2;
  localparam logic [1:0] RES_IO    = 2'd3;

  typedef enum logic [4:0] {
    S_IDLE, S_ACC_CHK, S_ACC_ASK, S_ACC_POLL, S_STS_CHK, S_STS_RDY,
    S_STS_POLL, S_BC_LO, S_BC_HI, S_CHUNK, S_PRE, S_LAST, S_POST,
    S_GO, S_CLN_RDY, S_CLN_REL, S_GAP, S_DONE
  } st_t;

  st_t              st, back;
  logic [CNT_W-1:0] elapsed;
  logic [GAP_W-1:0] gap;
  logic [LEN_W-1:0] rem, chunk;
  logic [7:0]       bc_lo;
  logic [1:0]       res;

  wire        owned   = (eng_rdata & ACC_OWNED) == ACC_OWNED;
  wire [15:0] bc      = {eng_rdata, bc_lo};
  wire        bc_less = 32'(bc) < 32'(rem);
  wire        to_a    = elapsed >= CNT_W'(TMO_A);
  wire        to_b    = elapsed >= CNT_W'(TMO_B);
  wire        to_d    = elapsed >= CNT_W'(TMO_D);
  wire        wr_bad  = eng_ack & eng_fail;

  assign busy     = st != S_IDLE;
  assign done     = st == S_DONE;
  assign err_code = res;
  assign cmd_take = eng_beat & ((st == S_CHUNK) | (st == S_LAST));

  always_comb begin
    eng_req   = 1'b1;
    eng_wr    = 1'b0;
    eng_addr  = RG_ACCESS;
    eng_wdata = 8'h00;
    eng_len   = LEN_W'(1);
    case (st)
      S_ACC_CHK, S_ACC_POLL: eng_addr = RG_ACCESS;
      S_ACC_ASK: begin eng_wr = 1'b1; eng_wdata = ACC_ASK; end
      S_STS_CHK, S_STS_POLL, S_PRE, S_POST: eng_addr = RG_STS;
      S_STS_RDY, S_CLN_RDY: begin eng_wr = 1'b1; eng_addr = RG_STS; eng_wdata = STS_RDY; end
      S_BC_LO: eng_addr = RG_BC_LO;
      S_BC_HI: eng_addr = RG_BC_HI;
      S_CHUNK: begin eng_wr = 1'b1; eng_addr = RG_FIFO; eng_wdata = cmd_byte; eng_len = chunk; end
      S_LAST:  begin eng_wr = 1'b1; eng_addr = RG_FIFO; eng_wdata = cmd_byte; end
      S_GO:    begin eng_wr = 1'b1; eng_addr = RG_STS; eng_wdata = STS_EXEC; end
      S_CLN_REL: begin eng_wr = 1'b1; eng_wdata = ACC_DROP; end
      default: eng_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      back    <= S_IDLE;
      elapsed <= '0;
      gap     <= '0;
      rem     <= '0;
      chunk   <= '0;
      bc_lo   <= '0;
      res     <= RES_OK;
    end else begin
      if (elapsed != '1) elapsed <= elapsed + 1'b1;
      case (st)
        S_IDLE:
          if (start) begin
            if (cmd_len < LEN_W'(MIN_LEN)) begin
              res <= RES_SHORT;
              st  <= S_DONE;
            end else begin
              res <= RES_OK;
              rem <= cmd_len - 1'b1;
              st  <= S_ACC_CHK;
            end
          end
        S_ACC_CHK:
          if (eng_ack) st <= owned ? S_STS_CHK : S_ACC_ASK;
        S_ACC_ASK:
          if (wr_bad) begin
            res <= RES_IO; st <= S_CLN_RDY;
          end else if (eng_ack) begin
            elapsed <= '0; st <= S_ACC_POLL;
          end
        S_ACC_POLL:
          if (eng_ack) begin
            if (owned) st <= S_STS_CHK;
            else if (to_a) begin res <= RES_TIME; st <= S_CLN_RDY; end
            else begin back <= S_ACC_POLL; gap <= '0; st <= S_GAP; end
          end
        S_STS_CHK:
          if (eng_ack) begin
            elapsed <= '0;
            st <= eng_rdata[BIT_RDY] ? S_BC_LO : S_STS_RDY;
          end
        S_STS_RDY:
          if (wr_bad) begin
            res <= RES_IO; st <= S_CLN_RDY;
          end else if (eng_ack) begin
            elapsed <= '0; st <= S_STS_POLL;
          end
        S_STS_POLL:
          if (eng_ack) begin
            if (eng_rdata[BIT_RDY]) begin elapsed <= '0; st <= S_BC_LO; end
            else if (to_b) begin res <= RES_TIME; st <= S_CLN_RDY; end
            else begin back <= S_STS_POLL; gap <= '0; st <= S_GAP; end
          end
        S_BC_LO:
          if (eng_ack) begin bc_lo <= eng_rdata; st <= S_BC_HI; end
        S_BC_HI:
          if (eng_ack) begin
            if (bc != 16'd0) begin
              chunk <= bc_less ? LEN_W'(bc) : rem;
              st    <= S_CHUNK;
            end else if (to_d) begin res <= RES_TIME; st <= S_CLN_RDY; end
            else begin back <= S_BC_LO; gap <= '0; st <= S_GAP; end
          end
        S_CHUNK:
          if (wr_bad) begin
            res <= RES_IO; st <= S_CLN_RDY;
          end else if (eng_ack) begin
            rem <= rem - chunk;
            if (rem == chunk) st <= S_PRE;
            else begin elapsed <= '0; st <= S_BC_LO; end
          end
        S_PRE:
          if (eng_ack) begin
            if (eng_rdata[BIT_EXP]) st <= S_LAST;
            else begin res <= RES_IO; st <= S_CLN_RDY; end
          end
        S_LAST:
          if (wr_bad) begin
            res <= RES_IO; st <= S_CLN_RDY;
          end else if (eng_ack) st <= S_POST;
        S_POST:
          if (eng_ack) begin
            if (!eng_rdata[BIT_EXP]) st <= S_GO;
            else begin res <= RES_IO; st <= S_CLN_RDY; end
          end
        S_GO:
          if (wr_bad) begin
            res <= RES_IO; st <= S_CLN_RDY;
          end else if (eng_ack) st <= S_DONE;
        S_CLN_RDY:
          if (eng_ack) st <= S_CLN_REL;
        S_CLN_REL:
          if (eng_ack) st <= S_DONE;
        S_GAP:
          if (gap == GAP_W'(POLL_GAP - 1)) st <= back;
          else gap <= gap + 1'b1;
        default:
          st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tpm_cmd_sender_chk.sv
module tpm_cmd_sender_chk #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] cmd_len,
  input logic             busy,
  input logic             done,
  input logic [1:0]       err_code,
  input logic             cmd_take,
  input logic             eng_req,
  input logic             eng_wr,
  input logic [7:0]       eng_addr,
  input logic [7:0]       eng_wdata,
  input logic             eng_ack
);

  logic [7:0] last_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_rd <= 8'h00;
    else if (eng_ack && !eng_wr) last_rd <= eng_addr;
  end

  AST_SHORT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cmd_len < LEN_W'(MIN_LEN)) |=> (done && err_code == 2'd1 && !eng_req)); // R1

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack) |=> (eng_req && $stable(eng_addr) && $stable(eng_wr))); // R13

  AST_TAKE_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |-> (eng_req && eng_wr && eng_addr == 8'h24)); // R6

  AST_BC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_addr == 8'h1A) |-> (last_rd == 8'h19)); // R5

  AST_GO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd0) |-> $past(eng_ack && eng_wr && eng_addr == 8'h18 && eng_wdata == 8'h20)); // R9

  AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code[1]) |-> $past(eng_ack && eng_wr && eng_addr == 8'h00 && eng_wdata == 8'h20)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !eng_req); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

endmodule

bind tpm_cmd_sender tpm_cmd_sender_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (.*);

// File: tb/test_tpm_cmd_sender.sv
module test_tpm_cmd_sender;
  localparam int LW = 16, GAP = 3, TMO = 60;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LW-1:0] cmd_len = '0, eng_len;
  logic busy, done, cmd_take, eng_req, eng_wr;
  logic [1:0] err_code;
  logic [7:0] cmd_byte = 8'h00, eng_addr, eng_wdata, eng_rdata = 8'h00;
  logic eng_ack = 1'b0, eng_fail = 1'b0, eng_beat = 1'b0;

  always #5 clk = ~clk;

  tpm_cmd_sender #(.LEN_W(LW), .MIN_LEN(10), .TMO_A(TMO), .TMO_B(TMO), .TMO_D(TMO),
                   .POLL_GAP(GAP)) i_tpm_cmd_sender (.*);

  int checks = 0, failures = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // device model knobs and state
  bit acc_init, crdy_init, de_pre, de_post_clear;
  int acc_grant, crdy_grant, fail_at, cur_len;
  int bq[$];
  bit acc_req, crdy_req;
  int acc_cnt, crdy_cnt, wcount, bytes_wr, ptr;
  logic [15:0] cur_bc;
  logic [32:0] log_q[$], exp_q[$];
  int st_q[$], ak_q[$];
  logic [7:0] got[$];
  int exp_err; bit exp_to;

  function automatic logic [7:0] cbyte(int i);
    return 8'(i * 37 + 5);
  endfunction

  function automatic logic [32:0] tr(bit w, logic [7:0] a, int l, logic [7:0] d);
    return {w, a, 16'(l), d};
  endfunction

  // engine and register model
  initial begin
    forever begin
      @(negedge clk);
      eng_ack = 1'b0; eng_fail = 1'b0; eng_beat = 1'b0;
      if (rst_n && eng_req) begin
        automatic bit w = eng_wr;
        automatic logic [7:0] a = eng_addr, d = eng_wdata, rd = 8'h00;
        automatic int l = int'(eng_len), s = cyc;
        automatic bit f = 1'b0;
        @(negedge clk);
        if (w && a == 8'h24) begin
          for (int k = 0; k < l; k++) begin
            eng_beat = 1'b1;
            #1;
            got.push_back(eng_wdata);
            chk(cmd_take === 1'b1, "R6", "cmd_take on beat", cmd_take, 1);
            @(negedge clk);
            eng_beat = 1'b0;
            ptr++;
            cmd_byte = cbyte(ptr);
          end
        end
        if (w) begin
          f = (fail_at == wcount);
          wcount++;
          if (!f) begin
            if (a == 8'h00 && d == 8'h02) acc_req = 1'b1;
            if (a == 8'h18 && d == 8'h40) crdy_req = 1'b1;
            if (a == 8'h24) bytes_wr += l;
          end
        end else begin
          case (a)
            8'h00: if (acc_init || (acc_req && acc_grant >= 0 && acc_cnt >= acc_grant)) rd = 8'hA0;
                   else begin rd = 8'h80; if (acc_req) acc_cnt++; end
            8'h18: begin
              automatic bit r = crdy_init || (crdy_req && crdy_grant >= 0 && crdy_cnt >= crdy_grant);
              automatic bit e = (bytes_wr >= cur_len) ? !de_post_clear : de_pre;
              if (!r && crdy_req) crdy_cnt++;
              rd = {1'b1, r, 2'b00, e, 3'b000};
            end
            8'h19: begin cur_bc = (bq.size() > 0) ? 16'(bq.pop_front()) : 16'd0; rd = cur_bc[7:0]; end
            8'h1A: rd = cur_bc[15:8];
            default: rd = 8'h00;
          endcase
        end
        log_q.push_back(tr(w, a, w ? l : 1, (w && a != 8'h24) ? d : 8'h00));
        st_q.push_back(s);
        ak_q.push_back(cyc);
        eng_rdata = rd; eng_fail = f; eng_ack = 1'b1;
      end
    end
  end

  // expected access sequence from the requirements
  int ewi;
  function automatic bit ew(logic [7:0] a, int l, logic [7:0] d);
    exp_q.push_back(tr(1'b1, a, l, d));
    ewi++;
    return (fail_at == ewi - 1);
  endfunction
  function automatic void io_end();
    exp_err = 3;
    exp_q.push_back(tr(1'b1, 8'h18, 1, 8'h40));
    exp_q.push_back(tr(1'b1, 8'h00, 1, 8'h20));
  endfunction

  function automatic void build();
    automatic int rem = cur_len - 1;
    automatic int bqc[$] = bq;
    exp_q.delete(); exp_to = 1'b0; exp_err = 0; ewi = 0;
    if (cur_len < 10) begin exp_err = 1; return; end
    exp_q.push_back(tr(0, 8'h00, 1, 0));                       // R2
    if (!acc_init) begin                                         // R3
      if (ew(8'h00, 1, 8'h02)) begin io_end(); return; end
      if (acc_grant < 0) begin exp_q.push_back(tr(0, 8'h00, 1, 0)); exp_to = 1; exp_err = 2; return; end
      repeat (acc_grant + 1) exp_q.push_back(tr(0, 8'h00, 1, 0));
    end
    exp_q.push_back(tr(0, 8'h18, 1, 0));                       // R4
    if (!crdy_init) begin
      if (ew(8'h18, 1, 8'h40)) begin io_end(); return; end
      if (crdy_grant < 0) begin exp_q.push_back(tr(0, 8'h18, 1, 0)); exp_to = 1; exp_err = 2; return; end
      repeat (crdy_grant + 1) exp_q.push_back(tr(0, 8'h18, 1, 0));
    end
    while (rem > 0) begin                                        // R5 R6
      automatic int b = (bqc.size() > 0) ? bqc.pop_front() : 0;
      exp_q.push_back(tr(0, 8'h19, 1, 0));
      exp_q.push_back(tr(0, 8'h1A, 1, 0));
      if (b == 0) begin
        if (bqc.size() == 0) begin exp_to = 1; exp_err = 2; return; end
      end else begin
        automatic int c = (b < rem) ? b : rem;
        if (ew(8'h24, c, 0)) begin io_end(); return; end
        rem -= c;
      end
    end
    exp_q.push_back(tr(0, 8'h18, 1, 0));                       // R7
    if (!de_pre) begin io_end(); return; end
    if (ew(8'h24, 1, 0)) begin io_end(); return; end           // R8
    exp_q.push_back(tr(0, 8'h18, 1, 0));
    if (!de_post_clear) begin io_end(); return; end
    if (ew(8'h18, 1, 8'h20)) begin io_end(); return; end       // R9
  endfunction

  task automatic setup(bit ai, int ag, bit ci, int cg, bit dp, bit dc, int fa);
    acc_init = ai; acc_grant = ag; crdy_init = ci; crdy_grant = cg;
    de_pre = dp; de_post_clear = dc; fail_at = fa;
    acc_req = 0; crdy_req = 0; acc_cnt = 0; crdy_cnt = 0; wcount = 0; bytes_wr = 0;
  endtask

  task automatic run(int len, string tag, bit restart);
    automatic int t = 0, bad = 0, sdone = 0;
    cur_len = len;
    build();
    log_q.delete(); st_q.delete(); ak_q.delete(); got.delete();
    ptr = 0; cmd_byte = cbyte(0);
    @(negedge clk);
    start = 1'b1; cmd_len = LW'(len);
    @(negedge clk);
    start = 1'b0;
    sdone = cyc;
    while (!done && t < 4000) begin @(negedge clk); t++; end
    chk(done === 1'b1, "R12", {tag, " done seen"}, done, 1);
    if (len < 10) chk(t == 0 && log_q.size() == 0, "R1", {tag, " immediate reject"}, t, 0);
    chk(err_code == 2'(exp_err), tag, "err_code", err_code, exp_err);
    if (!exp_to) begin
      chk(log_q.size() == exp_q.size(), tag, "access count", log_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
        if (log_q[i] != exp_q[i]) bad++;
      chk(bad == 0, tag, "access sequence mismatches", bad, 0);
    end else begin
      automatic int n = exp_q.size(), m = log_q.size();
      for (int i = 0; i < n && i < m; i++) if (log_q[i] != exp_q[i]) bad++;
      for (int i = n; i < m - 2; i++) if (log_q[i][32]) bad++;
      chk(bad == 0 && m >= n + 3, tag, "timeout poll sequence", bad, 0);
      chk(m >= 2 && log_q[m-2] == tr(1, 8'h18, 1, 8'h40) && log_q[m-1] == tr(1, 8'h00, 1, 8'h20),
          "R10", {tag, " cleanup pair"}, (m >= 1) ? log_q[m-1] : 0, tr(1, 8'h00, 1, 8'h20));
    end
    bad = 0;
    for (int i = 0; i < got.size(); i++) if (got[i] != cbyte(i)) bad++;
    chk(bad == 0, "R6", {tag, " byte order"}, bad, 0);
    if (exp_err == 0) chk(got.size() == len, "R6", {tag, " byte count"}, got.size(), len);
    bad = 0;
    for (int i = 1; i < log_q.size(); i++)
      if (!log_q[i][32] && !log_q[i-1][32] &&
          (log_q[i][31:24] == log_q[i-1][31:24] || (log_q[i][31:24] == 8'h19 && log_q[i-1][31:24] == 8'h1A)) &&
          st_q[i] - ak_q[i-1] < GAP + 1) bad++;
    chk(bad == 0, "R13", {tag, " poll spacing"}, bad, 0);
    if (restart) begin
      start = 1'b1; cmd_len = LW'(20);
      @(negedge clk);
      start = 1'b0;
      bad = 0;
      repeat (8) begin if (eng_req || busy) bad++; @(negedge clk); end
      chk(bad == 0, "R12", {tag, " start during done ignored"}, bad, 0);
    end else begin
      @(negedge clk);
      chk(!done && !busy, "R12", {tag, " done one cycle"}, done, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !done && !eng_req && !cmd_take, "R12", "reset state", {busy, done, eng_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    setup(1, 0, 1, 0, 1, 1, -1); bq = '{};         run(9,  "R1 short",  0);
    setup(1, 0, 1, 0, 1, 1, -1); bq = '{16};       run(10, "R2 minimal", 1);
    setup(0, 2, 0, 1, 1, 1, -1); bq = '{0, 0, 4, 0, 7, 100}; run(20, "R3 R4 R5 polls", 0);
    setup(0, -1, 1, 0, 1, 1, -1); bq = '{};        run(12, "R3 timeout", 0);
    setup(1, 0, 0, -1, 1, 1, -1); bq = '{};        run(12, "R4 timeout", 0);
    setup(1, 0, 1, 0, 1, 1, -1); bq = '{};         run(12, "R5 timeout", 0);
    setup(1, 0, 1, 0, 0, 1, -1); bq = '{50};       run(12, "R7 expect", 0);
    setup(1, 0, 1, 0, 1, 0, -1); bq = '{50};       run(12, "R8 expect", 0);
    setup(1, 0, 1, 0, 1, 1, 0);  bq = '{3, 50};    run(14, "R11 fail", 0);
    setup(1, 0, 1, 0, 1, 1, -1); bq = '{1, 2, 300}; run(11, "R9 R6 small", 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule